// File: doc/BRIEF.md
# Floppy Head Recalibration Step Sequencer

This block runs the head-recalibration operation of a floppy drive controller for one selected drive at a time. A start request latches the drive number, the step-count range mode, a settle delay and a step interval. The sequencer waits out the settle delay and drives the direction output to the outward state. It then issues step pulses until the drive reports its head at track zero, or until a ceiling on the number of pulses is reached.

On completion it posts a status byte and raises an interrupt. The status byte carries the drive number, a seek-end flag and an equipment-check flag, which tells software that the head never reached track zero. A sense-interrupt read lowers the interrupt. The status byte stays readable until the next operation completes. While an operation runs, a one-hot busy vector marks the drive concerned, and any further start requests are dropped.

Top module: `fdc_recal_seq`

## Requirements
- R1: The first step pulse becomes visible exactly settle_dly_i + 2 clock edges after the edge that accepts the start request (the edge at which the state leaves idle counts as edge 0).
- R2: Step pulses continue until trk0_i is seen active at a step decision point, and no further pulse follows; the number of pulses equals the number needed to reach track zero.
- R3: With ext_range_i = 0 at start, no more than 255 step pulses are issued.
- R4: With ext_range_i = 1 at start, no more than 3925 step pulses are issued.
- R5: On completion status_o is 8'h20 | (eq << 4) | drive, where bit 5 is seek end (always 1), bit 4 is equipment check (1 only when the ceiling was reached with trk0_i inactive), bits 1:0 hold the drive number, and all other bits are 0.
- R6: irq_o rises in the same cycle that busy drops, stays high until a cycle with sense_rd_i = 1, then is 0; status_o is unchanged by the sense read.
- R7: While an operation runs, busy_o has exactly the bit of the selected drive set (bit i for drive i), and it is all zero when idle.
- R8: dir_o is 1 (outward) from the cycle after start until completion and is already 1 in the cycle before the first step pulse; step_o and dir_o are 0 when idle.
- R9: Each step pulse is high for PULSE_CLKS clocks (default 2), and consecutive pulses are separated by step_gap_i + 2 low clocks.
- R10: If trk0_i is already active when the settle delay ends, no pulse is issued and status reports success (equipment check 0).
- R11: A start request while an operation is running is ignored: the drive, mode and pulse count of the running operation are unaffected.
- R12: After reset step_o, dir_o, irq_o, busy_o and status_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| drive_sel_i | input | 2 | Drive number for the request |
| ext_range_i | input | 1 | 0: ceiling 255 pulses, 1: ceiling 3925 pulses |
| settle_dly_i | input | 8 | Delay before the first step decision, in clocks |
| step_gap_i | input | 8 | Step interval setting, in clocks |
| trk0_i | input | 1 | Head-at-track-zero indication from the drive |
| sense_rd_i | input | 1 | Sense-interrupt read strobe, clears the interrupt |
| step_o | output | 1 | Step pulse to the drive |
| dir_o | output | 1 | Step direction, 1 = outward |
| busy_o | output | 4 | One-hot per-drive busy flags |
| irq_o | output | 1 | Completion interrupt |
| status_o | output | 8 | Completion status byte |

## Verification
The assertions watch on every cycle that the busy vector is one-hot or empty, that a track-zero indication at a decision point blocks the next pulse, that the interrupt rises only as busy falls, that a start during an operation leaves the latched drive unchanged, that an equipment-check report follows a ceiling hit, and that the pulse counter never passes its ceiling. The timing relations can only be shown by the bench scenarios: the settle latency to the first pulse, the pulse widths and gaps, and the exact pulse counts against both ceilings, including a track zero reached on the very last allowed pulse. The same holds for the exact status byte and the interrupt clear by a sense read.

// File: rtl/fdc_recal_pkg.sv
package fdc_recal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_CHECK, ST_STEP, ST_GAP
  } rc_state_e;

  localparam int ST0_SEEK_END = 5;
  localparam int ST0_EQ_CHK   = 4;
endpackage

// File: rtl/fdc_recal_timer.sv
module fdc_recal_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fdc_recal_step_cnt.sv
module fdc_recal_step_cnt #(
  parameter int SHORT_MAX = 255,
  parameter int LONG_MAX  = 3925,
  parameter int CNT_W     = $clog2(LONG_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic ext_i,
  output logic limit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = ext_i ? CNT_W'(LONG_MAX) : CNT_W'(SHORT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign limit_o = (cnt_q == limit);

  // R3 R4
  cnt_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= CNT_W'(LONG_MAX)) && (!ext_i -> cnt_q <= CNT_W'(SHORT_MAX)));
endmodule

// File: rtl/fdc_recal_seq.sv
module fdc_recal_seq
  import fdc_recal_pkg::*;
#(
  parameter int NUM_DRV    = 4,
  parameter int DLY_W      = 8,
  parameter int GAP_W      = 8,
  parameter int PULSE_CLKS = 2,
  parameter int SHORT_MAX  = 255,
  parameter int LONG_MAX   = 3925,
  localparam int DRV_W     = $clog2(NUM_DRV),
  localparam int TMR_W     = (DLY_W > GAP_W) ? DLY_W : GAP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DRV_W-1:0]   drive_sel_i,
  input  logic               ext_range_i,
  input  logic [DLY_W-1:0]   settle_dly_i,
  input  logic [GAP_W-1:0]   step_gap_i,
  input  logic               trk0_i,
  input  logic               sense_rd_i,
  output logic               step_o,
  output logic               dir_o,
  output logic [NUM_DRV-1:0] busy_o,
  output logic               irq_o,
  output logic [7:0]         status_o
);
  rc_state_e        state_q, state_d;
  logic [DRV_W-1:0] drv_q;
  logic             ext_q;
  logic [GAP_W-1:0] gap_q;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             sc_clr, sc_inc, sc_limit;
  logic             done;
  logic             irq_q;
  logic [7:0]       st_q, st_d;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  fdc_recal_timer #(.W(TMR_W)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  fdc_recal_step_cnt #(.SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)) u_step_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (sc_clr), .inc_i (sc_inc), .ext_i (ext_q), .limit_o(sc_limit)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sc_clr   = 1'b0;
    sc_inc   = 1'b0;
    done     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(settle_dly_i);
        sc_clr   = 1'b1;
      end
      ST_SETTLE: if (tmr_zero) state_d = ST_CHECK;
      ST_CHECK: begin
        // track zero wins over the ceiling
        if (trk0_i || sc_limit) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_STEP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PULSE_CLKS - 1);
          sc_inc   = 1'b1;
        end
      end
      ST_STEP: if (tmr_zero) begin
        state_d  = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(gap_q);
      end
      ST_GAP: if (tmr_zero) state_d = ST_CHECK;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    st_d                = '0;
    st_d[DRV_W-1:0]     = drv_q;
    st_d[ST0_SEEK_END]  = 1'b1;
    st_d[ST0_EQ_CHK]    = ~trk0_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      drv_q   <= '0;
      ext_q   <= 1'b0;
      gap_q   <= '0;
      irq_q   <= 1'b0;
      st_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        drv_q <= drive_sel_i;
        ext_q <= ext_range_i;
        gap_q <= step_gap_i;
      end
      if (done) begin
        irq_q <= 1'b1;
        st_q  <= st_d;
      end else if (sense_rd_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_busy
    assign busy_o[i] = (state_q != ST_IDLE) && (drv_q == DRV_W'(i));
  end

  assign step_o   = (state_q == ST_STEP);
  assign dir_o    = (state_q != ST_IDLE);
  assign irq_o    = irq_q;
  assign status_o = st_q;

  // R7
  busy_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_o));

  // R2 R10
  trk0_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && trk0_i) |=> !step_o && !dir_o);

  // R6
  irq_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(|busy_o));

  // R11
  busy_start_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(drv_q) && $stable(ext_q));

  // R5
  eq_only_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && status_o[ST0_EQ_CHK]) |-> $past(sc_limit));

  // R8
  dir_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_o) |-> $past(dir_o));
endmodule

// File: tb/fdc_recal_seq_tb.sv
module fdc_recal_seq_tb;
  localparam int PW = 2;

  typedef struct packed {
    logic [1:0]  drv;
    logic        ext;
    logic [7:0]  settle;
    logic [7:0]  gap;
    logic [11:0] trk_at;
    logic [11:0] exp_pulses;
    logic        exp_eq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd3, 8'd2, 12'd5,    12'd5,    1'b0},
    '{2'd1, 1'b0, 8'd0, 8'd0, 12'd0,    12'd0,    1'b0},
    '{2'd2, 1'b0, 8'd1, 8'd1, 12'd4095, 12'd255,  1'b1},
    '{2'd3, 1'b1, 8'd2, 8'd0, 12'd300,  12'd300,  1'b0},
    '{2'd1, 1'b1, 8'd0, 8'd0, 12'd4095, 12'd3925, 1'b1},
    '{2'd0, 1'b0, 8'd5, 8'd3, 12'd255,  12'd255,  1'b0},
    '{2'd2, 1'b1, 8'd0, 8'd0, 12'd3925, 12'd3925, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] drive_sel_i = '0;
  logic       ext_range_i = 1'b0;
  logic [7:0] settle_dly_i = '0;
  logic [7:0] step_gap_i = '0;
  logic       trk0_i = 1'b0;
  logic       sense_rd_i = 1'b0;
  logic       step_o, dir_o, irq_o;
  logic [3:0] busy_o;
  logic [7:0] status_o;

  fdc_recal_seq u_dut (
    .clk_i, .rst_ni, .start_i, .drive_sel_i, .ext_range_i, .settle_dly_i,
    .step_gap_i, .trk0_i, .sense_rd_i, .step_o, .dir_o, .busy_o, .irq_o, .status_o
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int seen = 0, trk_at = 0, cur_gap = 0, first_lat = -1, cyc = 0;
  int hi_len = 0, lo_len = 0, bad_w = 0, bad_g = 0, bad_d = 0;
  bit arm = 0, in_op = 0, prev = 0;
  logic [3:0] busy_seen, busy_intr;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // negedge monitor: step timing and the track-zero model
  always @(negedge clk_i) begin
    if (arm && start_i) begin in_op = 1; cyc = 0; arm = 0; end
    else if (in_op) cyc++;
    if (in_op) begin
      if (step_o && !prev) begin
        if (seen == 0) first_lat = cyc;
        else if (lo_len != cur_gap + 2) bad_g++;
        if (!dir_o) bad_d++;
        seen++;
        hi_len = 1;
      end else if (step_o) hi_len++;
      else if (prev) begin
        if (hi_len != PW) bad_w++;
        lo_len = 1;
      end else lo_len++;
    end
    prev = step_o;
    trk0_i = (seen >= trk_at);
  end

  task automatic run_op(input logic [1:0] drv, input logic ext, input int settle,
                        input int gap, input int trk, input int intrude);
    int cnt;
    @(posedge clk_i); #2;
    trk_at = trk; seen = 0; bad_w = 0; bad_g = 0; bad_d = 0;
    first_lat = -1; cur_gap = gap;
    drive_sel_i = drv; ext_range_i = ext;
    settle_dly_i = 8'(settle); step_gap_i = 8'(gap);
    @(posedge clk_i); #2;
    start_i = 1'b1; arm = 1;
    @(posedge clk_i); #2;
    start_i = 1'b0;
    busy_seen = busy_o;
    busy_intr = busy_o;
    cnt = 0;
    while (!irq_o && cnt < 20000) begin
      @(posedge clk_i); #2;
      cnt++;
      if (intrude != 0 && cnt == intrude) begin
        start_i = 1'b1; drive_sel_i = drv ^ 2'b10; ext_range_i = ~ext;
      end else start_i = 1'b0;
      if (intrude != 0 && cnt == intrude + 2) busy_intr = busy_o;
    end
    start_i = 1'b0;
    @(negedge clk_i);
    in_op = 0;
  endtask

  task automatic sense_and_check(input logic [7:0] exp_st);
    @(posedge clk_i); #2;
    chk("R6 irq held", int'(irq_o), 1);
    sense_rd_i = 1'b1;
    @(posedge clk_i); #2;
    sense_rd_i = 1'b0;
    chk("R6 irq cleared", int'(irq_o), 0);
    chk("R6 status kept", int'(status_o), int'(exp_st));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R12 reset state
    #5;
    chk("R12 step", int'(step_o), 0);
    chk("R12 dir", int'(dir_o), 0);
    chk("R12 irq", int'(irq_o), 0);
    chk("R12 busy", int'(busy_o), 0);
    chk("R12 status", int'(status_o), 0);
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk("R12 after release busy", int'(busy_o), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      logic [7:0] exp_st;
      v = VECS[i];
      run_op(v.drv, v.ext, int'(v.settle), int'(v.gap), int'(v.trk_at), 0);
      if (v.trk_at == 0) tag = "R10 pulses";
      else if (v.exp_eq || v.trk_at >= 255) tag = v.ext ? "R4 pulses" : "R3 pulses";
      else tag = "R2 pulses";
      chk(tag, seen, int'(v.exp_pulses));
      if (v.exp_pulses != 0) chk("R1 settle latency", first_lat, int'(v.settle) + 3);
      chk("R9 width", bad_w, 0);
      chk("R9 gap", bad_g, 0);
      chk("R8 dir lead", bad_d, 0);
      chk("R7 busy", int'(busy_seen), 1 << v.drv);
      exp_st = 8'h20 | (8'(v.exp_eq) << 4) | 8'(v.drv);
      chk("R5 status", int'(status_o), int'(exp_st));
      chk("R6 irq", int'(irq_o), 1);
      chk("R8 idle dir", int'(dir_o), 0);
      chk("R7 idle busy", int'(busy_o), 0);
      sense_and_check(exp_st);
    end

    // R11 start while busy is ignored
    run_op(2'd1, 1'b0, 0, 0, 20, 10);
    chk("R11 pulses", seen, 20);
    chk("R11 busy kept", int'(busy_intr), 4'b0010);
    chk("R11 status", int'(status_o), 8'h21);
    sense_and_check(8'h21);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule